// File: doc/BRIEF.md
# Ready-Pacing Stream Sink

This block terminates a ready/valid input stream into a small first-in first-out store, which a downstream consumer empties through a simple pop port. Its purpose is to stress the producer feeding it: a pacing mode, which can be rewritten at run time, decides how the ready line behaves. The three behaviours are waiting for valid before offering ready, offering ready whenever there is space, and offering ready on a pseudo-random subset of cycles.

A full store always wins over the pacing mode, so no packet is ever lost. The random pattern comes from a 16-bit linear-feedback shift register. Software can reseed it through a dedicated write strobe. The block does not interpret the packets; it only moves them in order.

Top module: `paced_sink`

## Requirements
- R1: While `rstN` is low, `inReady` and `popAvail` are 0. After reset the store is empty and the pacing mode is eager (1), so `inReady` is 1 in the first cycle after release.
- R2: A packet is taken only at a rising clock edge where `inValid` and `inReady` are both 1. Taken packets come out of the pop port in the order they were taken.
- R3: When the store holds DEPTH packets, `inReady` is 0 in every mode, and nothing more is written.
- R4: In wait mode (`modeIn` = 0), `inReady` is 0 until `inValid` has been sampled 1 at a clock edge. It is then 1 from the next cycle, stays 1 while no packet is taken even if `inValid` drops, and returns to 0 in the cycle after each taken packet. Under a constant stream this gives one accept every other cycle.
- R5: In eager mode (`modeIn` = 1), `inReady` is 1 whenever the store is not full. A `modeIn` value of 3 behaves exactly like 1.
- R6: In random mode (`modeIn` = 2), `inReady` equals bit 0 of the shift register AND not-full. Every cycle the register shifts left by one, and bit 0 takes the XOR of bits 15, 13, 12 and 10. Its reset value is 16'hACE1.
- R7: A cycle with `seedWe` = 1 and a nonzero `seedIn` loads `seedIn` into the shift register instead of shifting. A zero seed is ignored and the register shifts as usual, so it never holds zero.
- R8: A cycle with `modeWe` = 1 writes `modeIn` into the mode register. The new mode governs `inReady` from the next cycle; in the write cycle the old mode still applies.
- R9: `popAvail` is 1 when the store is not empty, and `popData` shows the oldest packet. A `popReq` at a clock edge removes that packet. A `popReq` while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Producer offers a packet |
| inData | input | DATA_W | Packet from the producer |
| inReady | output | 1 | Sink accepts the packet this cycle |
| modeWe | input | 1 | Write strobe for the pacing mode |
| modeIn | input | 2 | New pacing mode: 0 wait, 1 eager, 2 random, 3 eager |
| seedWe | input | 1 | Write strobe for the shift-register seed |
| seedIn | input | LFSR_W | New seed; zero is ignored |
| popReq | input | 1 | Consumer removes the oldest packet |
| popData | output | DATA_W | Oldest stored packet |
| popAvail | output | 1 | Store holds at least one packet |

## Verification
Wait mode is driven from a cycle table with valid held high, valid pulsed, and valid dropping after ready was offered. This separates a registered arm that holds its state from one that merely follows valid, and it shows the one-cycle gap after every accept. Eager mode and its alias value are driven with a steady stream until the store fills and then released by single pops, which shows full-store backpressure winning over the mode. Random mode runs with valid both idle and busy against an independent model of the shift register, before and after a nonzero and a zero reseed. The order of the drained data is checked after every phase, and so is a pop issued while the store is empty.

// File: rtl/paced_sink_pkg.sv
package paced_sink_pkg;

  typedef enum logic [1:0] {
    PACE_WAIT      = 2'd0,
    PACE_EAGER     = 2'd1,
    PACE_RANDOM    = 2'd2,
    PACE_EAGER_ALT = 2'd3
  } paceMode_e;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

endpackage

// File: rtl/paced_sink_fifo.sv
module paced_sink_fifo
  import paced_sink_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              fifoFull,
  output logic              fifoEmpty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData    = mem[rdPtr];
  assign fifoFull  = (count == FULL_CNT);
  assign fifoEmpty = (count == '0);

endmodule

// File: rtl/paced_sink_ctrl.sv
module paced_sink_ctrl
  import paced_sink_pkg::*;
#(
  parameter int          LFSR_W     = 16,
  parameter logic [15:0] LFSR_TAPS  = 16'hB400,
  parameter logic [15:0] SEED_RESET = 16'hACE1,
  parameter paceMode_e   RESET_MODE = PACE_EAGER
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              modeWe,
  input  logic [1:0]        modeIn,
  input  logic              seedWe,
  input  logic [LFSR_W-1:0] seedIn,
  input  logic              popReq,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output logic              inReady,
  output fifoStrobe_t       strobe,
  output paceMode_e         modeQ,
  output logic [LFSR_W-1:0] lfsrQ
);

  localparam logic [LFSR_W-1:0] TAP_MASK  = LFSR_W'(LFSR_TAPS);
  localparam logic [LFSR_W-1:0] SEED_INIT = LFSR_W'(SEED_RESET);

  logic armQ;
  logic paceOk;
  logic feedback;

  assign feedback = ^(lfsrQ & TAP_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= RESET_MODE;
    else if (modeWe) modeQ <= paceMode_e'(modeIn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= SEED_INIT;
    else if (seedWe && (seedIn != '0)) lfsrQ <= seedIn;
    else lfsrQ <= {lfsrQ[LFSR_W-2:0], feedback};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armQ <= 1'b0;
    else if (modeQ != PACE_WAIT) armQ <= 1'b0;
    else if (strobe.push) armQ <= 1'b0;
    else if (inValid) armQ <= 1'b1;
  end

  always_comb begin
    case (modeQ)
      PACE_WAIT:   paceOk = armQ;
      PACE_RANDOM: paceOk = lfsrQ[0];
      default:     paceOk = 1'b1;
    endcase
  end

  assign inReady     = rstN & ~fifoFull & paceOk;
  assign strobe.push = inValid & inReady;
  assign strobe.pop  = popReq & ~fifoEmpty;

endmodule

// File: rtl/paced_sink.sv
module paced_sink
  import paced_sink_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int LFSR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  input  logic              modeWe,
  input  logic [1:0]        modeIn,
  input  logic              seedWe,
  input  logic [LFSR_W-1:0] seedIn,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              popAvail
);

  fifoStrobe_t       strobe;
  logic              fifoFull;
  logic              fifoEmpty;
  paceMode_e         modeQ;
  logic [LFSR_W-1:0] lfsrQ;

  paced_sink_ctrl #(
    .LFSR_W(LFSR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .modeWe(modeWe), .modeIn(modeIn),
    .seedWe(seedWe), .seedIn(seedIn),
    .popReq(popReq), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .inReady(inReady), .strobe(strobe), .modeQ(modeQ), .lfsrQ(lfsrQ)
  );

  paced_sink_fifo #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) uFifo (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(inData),
    .rdData(popData), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  assign popAvail = rstN & ~fifoEmpty;

endmodule

// File: rtl/paced_sink_chk.sv
module paced_sink_chk
  import paced_sink_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              modeWe,
  input logic [1:0]        modeIn,
  input logic              seedWe,
  input logic [LFSR_W-1:0] seedIn,
  input logic              popReq,
  input logic              popAvail,
  input logic              fifoFull,
  input paceMode_e         modeQ,
  input logic [LFSR_W-1:0] lfsrQ
);

  // R3
  full_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !inReady);

  // R4
  wait_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == PACE_WAIT && $past(modeQ) == PACE_WAIT && $past(inValid && inReady))
      |-> !inReady);

  // R5
  eager_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeQ == PACE_EAGER || modeQ == PACE_EAGER_ALT) && !fifoFull) |-> inReady);

  // R7
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seedWe && seedIn != '0) |=> (lfsrQ == $past(seedIn)));

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  // R8
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeWe |=> (modeQ == paceMode_e'($past(modeIn))));

  // R2
  push_avail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> popAvail);

  // R9
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!popAvail && popReq && !(inValid && inReady)) |=> !popAvail);

endmodule

bind paced_sink paced_sink_chk #(.LFSR_W(LFSR_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .modeWe(modeWe), .modeIn(modeIn), .seedWe(seedWe), .seedIn(seedIn),
  .popReq(popReq), .popAvail(popAvail), .fifoFull(fifoFull),
  .modeQ(modeQ), .lfsrQ(lfsrQ)
);

// File: tb/tb_paced_sink.sv
`timescale 1ns/1ps
module tb_paced_sink;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int LFSR_W = 16;

  // wait-mode table, bits {inValid, popReq, expReady, expAvail}
  localparam int WAIT_N = 17;
  localparam logic [3:0] WAIT_TBL [WAIT_N] = '{
    4'b0000, 4'b1000, 4'b1010, 4'b1001, 4'b1011, 4'b0001, 4'b0001,
    4'b1001, 4'b0011, 4'b0011, 4'b1011, 4'b1001, 4'b1011, 4'b1001,
    4'b1001, 4'b1101, 4'b1011
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic inReady;
  logic modeWe = 1'b0;
  logic [1:0] modeIn = 2'd0;
  logic seedWe = 1'b0;
  logic [LFSR_W-1:0] seedIn = '0;
  logic popReq = 1'b0;
  logic [DATA_W-1:0] popData;
  logic popAvail;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] expQ [$];
  logic [LFSR_W-1:0] mdl;
  int readyHigh = 0;

  always #2.5 clk = ~clk;

  paced_sink #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LFSR_W(LFSR_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(inReady), .modeWe(modeWe), .modeIn(modeIn),
    .seedWe(seedWe), .seedIn(seedIn), .popReq(popReq),
    .popData(popData), .popAvail(popAvail)
  );

  // R6 shift-register model from the stated polynomial
  always @(posedge clk or negedge rstN) begin
    if (!rstN) mdl <= 16'hACE1;
    else if (seedWe && seedIn != '0) mdl <= seedIn;
    else mdl <= {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // advance one cycle, update scoreboard, return just after the next negedge
  task automatic tick();
    bit acc = inValid && inReady;
    bit pp  = popReq && popAvail;
    logic [DATA_W-1:0] d = inData;
    @(posedge clk);
    if (pp && expQ.size() > 0) void'(expQ.pop_front());
    if (acc) expQ.push_back(d);
    @(negedge clk);
  endtask

  task automatic setMode(input logic [1:0] m);
    modeWe = 1'b1; modeIn = m;
    tick();
    modeWe = 1'b0;
  endtask

  task automatic drain(input string tag);
    inValid = 1'b0;
    while (expQ.size() > 0) begin
      popReq = 1'b1;
      #1;
      check(popAvail === 1'b1, tag, popAvail, 1);
      check(popData === expQ[0], tag, popData, expQ[0]);
      tick();
    end
    popReq = 1'b0;
    #1;
    check(popAvail === 1'b0, tag, popAvail, 0);
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1 reset state
    inValid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(inReady === 1'b0, "R1 ready in reset", inReady, 0);
    check(popAvail === 1'b0, "R1 avail in reset", popAvail, 0);
    inValid = 1'b0;
    rstN = 1'b1;
    #1;
    check(inReady === 1'b1, "R1 eager after reset", inReady, 1);
    @(negedge clk);

    // R8 mode write: old mode holds in write cycle
    modeWe = 1'b1; modeIn = 2'd0;
    #1;
    check(inReady === 1'b1, "R8 old mode in write cycle", inReady, 1);
    tick();
    modeWe = 1'b0;
    #1;
    check(inReady === 1'b0, "R8 new wait mode applies", inReady, 0);

    // R4 wait-mode table walk
    for (int i = 0; i < WAIT_N; i++) begin
      inValid = WAIT_TBL[i][3];
      popReq  = WAIT_TBL[i][2];
      inData  = 8'h40 + 8'(i);
      #1;
      check(inReady === WAIT_TBL[i][1], $sformatf("R4 ready step %0d", i),
            inReady, WAIT_TBL[i][1]);
      check(popAvail === WAIT_TBL[i][0], $sformatf("R9 avail step %0d", i),
            popAvail, WAIT_TBL[i][0]);
      tick();
    end
    popReq = 1'b0;
    check(expQ.size() == DEPTH, "R3 store full after table", expQ.size(), DEPTH);
    drain("R2 order after wait mode");

    // R5 eager mode under a constant stream
    setMode(2'd1);
    inValid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      inData = 8'h60 + 8'(i);
      #1;
      check(inReady === (expQ.size() < DEPTH), "R5 eager ready", inReady,
            expQ.size() < DEPTH);
      tick();
    end
    popReq = 1'b1; inData = 8'h70;
    #1;
    check(inReady === 1'b0, "R3 full overrides eager", inReady, 0);
    tick();
    popReq = 1'b0;
    #1;
    check(inReady === 1'b1, "R5 ready after pop", inReady, 1);

    // R5 mode value 3 acts as eager
    inValid = 1'b0;
    setMode(2'd3);
    inValid = 1'b1; inData = 8'h71;
    #1;
    check(inReady === 1'b1, "R5 mode 3 ready with room", inReady, 1);
    tick();
    #1;
    check(inReady === 1'b0, "R3 mode 3 full", inReady, 0);
    inValid = 1'b0;
    drain("R2 order after eager mode");

    // R9 pop while empty is ignored
    popReq = 1'b1;
    #1;
    check(popAvail === 1'b0, "R9 empty before pop", popAvail, 0);
    tick();
    popReq = 1'b0;
    #1;
    check(popAvail === 1'b0, "R9 empty pop ignored", popAvail, 0);
    inValid = 1'b1; inData = 8'hA5;
    tick();
    inValid = 1'b0;
    #1;
    check(popAvail === 1'b1 && popData === 8'hA5, "R9 head after empty pop",
          popData, 8'hA5);
    drain("R9 drain");

    // R6 R7 random mode
    seedWe = 1'b1; seedIn = 16'h0001;
    tick();
    seedWe = 1'b0;
    #1;
    check(mdl === 16'h0001, "R7 seed model", mdl, 16'h0001);
    check(inReady === 1'b1, "R7 seed loaded still eager", inReady, 1);
    setMode(2'd2);
    for (int i = 0; i < 40; i++) begin
      #1;
      check(inReady === mdl[0], "R6 random idle", inReady, mdl[0]);
      if (inReady) readyHigh++;
      tick();
    end
    check(readyHigh > 0 && readyHigh < 40, "R6 pattern mixes", readyHigh, 20);
    inValid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      inData = 8'h80 + 8'(i);
      popReq = i[0] & i[2];
      #1;
      check(inReady === (mdl[0] && expQ.size() < DEPTH), "R6 random busy",
            inReady, mdl[0] && expQ.size() < DEPTH);
      tick();
    end
    inValid = 1'b0; popReq = 1'b0;
    seedWe = 1'b1; seedIn = '0;
    tick();
    seedWe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      #1;
      check(inReady === (mdl[0] && expQ.size() < DEPTH), "R7 zero seed ignored",
            inReady, mdl[0] && expQ.size() < DEPTH);
      tick();
    end
    setMode(2'd1);
    drain("R2 order after random mode");

    finish();
  end

endmodule